// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block sits between a CPU data port and a byte-wide nonvolatile array of 16 rows by 128 bytes. The CPU writes bytes into a bank of column latches instead of into the array. Each latch carries its own valid flag. When a two-byte unlock sequence is written to the control port, every flagged byte is committed to a single row in one programming pass. A cycle-counted timer stands in for the cell programming time. The array is held in ordinary registers.

Reads go straight to the array. They return data one cycle after the request. While a programming pass is running, reads are refused: they return FFh with an error pulse. Access from the CPU port is gated by an enable bit that lives in the control port.

Top module: `paged_nvm_writer`

## Requirements
- R1: After reset, busy_o, mem_rvalid_o and mem_rd_err_o are 0, and every array byte reads FFh (erased).
- R2: A control write whose value is neither 54h nor A4h loads the access enable from data bit 0. While the enable is 0, byte writes are dropped and reads give no mem_rvalid_o pulse.
- R3: mem_addr_i[10:7] selects the row and mem_addr_i[6:0] selects the byte within the row. Bytes of other rows are not touched by a pass.
- R4: A pass writes only the flagged bytes. Unflagged bytes of the row keep their earlier value. Any count from 1 to 128 bytes can be committed.
- R5: The first accepted byte write of a session fixes the row. Later writes naming another row are dropped. A second write to the same column replaces the latched byte.
- R6: A pass starts only on control write A4h directly after control write 54h. Any other control write between the two cancels the sequence.
- R7: busy_o stays high for exactly PROG_CYCLES clock cycles (default 64). The array takes the new bytes in the last of those cycles.
- R8: All latch flags and the row lock are cleared when a pass ends, so a repeated unlock without new writes starts nothing.
- R9: An unlock sequence with no flagged latch leaves busy_o low.
- R10: While busy, byte writes and unlock sequences are ignored.
- R11: A read while busy returns FFh with mem_rvalid_o and a one-cycle mem_rd_err_o pulse.
- R12: A read requested at one clock edge presents mem_rdata_o with a one-cycle mem_rvalid_o pulse after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: unlock keys, or enable in bit 0 |
| mem_we_i | input | 1 | Byte write to the column latches |
| mem_re_i | input | 1 | Byte read from the array |
| mem_addr_i | input | 11 | Byte address: row in [10:7], column in [6:0] |
| mem_wdata_i | input | 8 | Byte write data |
| mem_rdata_o | output | 8 | Read data |
| mem_rvalid_o | output | 1 | Read data valid, one cycle |
| mem_rd_err_o | output | 1 | Read refused because a pass is running, one cycle |
| busy_o | output | 1 | Programming pass in progress |

## Verification
The hardest state to reach is a pass in flight with traffic arriving during it. The port shows only busy_o, so a write or unlock that is wrongly accepted while busy stays hidden until later. The stimulus therefore starts a pass and, inside the busy window, issues a read, a byte write and a full unlock sequence. It then waits for the pass to end and reads back the column that was written while busy. It also retries the unlock, which must not start a second pass. A full 128-byte page, a cancelled unlock and a write to a foreign row are driven as well, each followed by readback around the touched bytes.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h54;
  localparam logic [7:0] KEY_SECOND = 8'hA4;
  localparam logic [7:0] ERASED     = 8'hFF;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
  parameter logic [7:0] KEY_A = 8'h54,
  parameter logic [7:0] KEY_B = 8'hA4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  input  logic       hold_i,
  output logic       fire_o
);
  logic armed_q;

  assign fire_o = we_i && !hold_i && armed_q && (data_i == KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (hold_i) armed_q <= 1'b0;
    else if (we_i)   armed_q <= (data_i == KEY_A);
  end
endmodule

// File: rtl/nvm_col_latch.sv
module nvm_col_latch #(
  parameter int ROW_W = 4,
  parameter int COL_W = 7,
  localparam int COLS = 1 << COL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [7:0]            data_i,
  input  logic                  clear_i,
  output logic [ROW_W-1:0]      row_o,
  output logic [COLS-1:0]       flags_o,
  output logic [COLS-1:0][7:0]  data_o
);
  logic             locked_q;
  logic [ROW_W-1:0] row_q;
  logic             accept;

  // first accepted write locks the row; foreign rows are dropped
  assign accept = we_i && (!locked_q || row_i == row_q);
  assign row_o  = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      row_q    <= '0;
    end else if (clear_i) begin
      locked_q <= 1'b0;
    end else if (accept && !locked_q) begin
      locked_q <= 1'b1;
      row_q    <= row_i;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[c] <= 1'b0;
        data_o[c]  <= '0;
      end else if (clear_i) begin
        flags_o[c] <= 1'b0;
      end else if (accept && col_i == COL_W'(c)) begin
        flags_o[c] <= 1'b1;
        data_o[c]  <= data_i;
      end
    end
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ROW_W = 4,
  parameter int COL_W = 7,
  parameter logic [7:0] INIT = 8'hFF,
  localparam int ROWS = 1 << ROW_W,
  localparam int COLS = 1 << COL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ROW_W-1:0]      wr_row_i,
  input  logic [COLS-1:0]       mask_i,
  input  logic [COLS-1:0][7:0]  data_i,
  input  logic [ROW_W-1:0]      rd_row_i,
  input  logic [COL_W-1:0]      rd_col_i,
  output logic [7:0]            rd_data_o
);
  logic [COLS-1:0][7:0] mem_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int c = 0; c < COLS; c++) mem_q[r][c] <= INIT;
      end else if (we_i && wr_row_i == ROW_W'(r)) begin
        for (int c = 0; c < COLS; c++)
          if (mask_i[c]) mem_q[r][c] <= data_i[c];
      end
    end
  end

  assign rd_data_o = mem_q[rd_row_i][rd_col_i];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int CYCLES = 64,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end
  end
endmodule

// File: rtl/paged_nvm_writer.sv
module paged_nvm_writer #(
  parameter int ROW_W       = 4,
  parameter int COL_W       = 7,
  parameter int PROG_CYCLES = 64,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int COLS   = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              mem_we_i,
  input  logic              mem_re_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o,
  output logic              mem_rvalid_o,
  output logic              mem_rd_err_o,
  output logic              busy_o
);
  import nvm_pkg::*;

  logic                 en_q;
  logic                 fire, start, done;
  logic [ROW_W-1:0]     lat_row;
  logic [COLS-1:0]      lat_flags;
  logic [COLS-1:0][7:0] lat_data;
  logic [7:0]           arr_rdata;
  logic [ROW_W-1:0]     addr_row;
  logic [COL_W-1:0]     addr_col;

  assign addr_row = mem_addr_i[ADDR_W-1:COL_W];
  assign addr_col = mem_addr_i[COL_W-1:0];

  // non-key control writes carry the enable bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (ctl_we_i && ctl_wdata_i != KEY_FIRST && ctl_wdata_i != KEY_SECOND)
      en_q <= ctl_wdata_i[0];
  end

  nvm_unlock #(.KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) u_unlock (
    .clk_i, .rst_ni,
    .we_i   (ctl_we_i),
    .data_i (ctl_wdata_i),
    .hold_i (busy_o),
    .fire_o (fire)
  );

  assign start = fire && (|lat_flags);

  nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (busy_o),
    .done_o  (done)
  );

  nvm_col_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
    .clk_i, .rst_ni,
    .we_i    (mem_we_i && en_q && !busy_o),
    .row_i   (addr_row),
    .col_i   (addr_col),
    .data_i  (mem_wdata_i),
    .clear_i (done),
    .row_o   (lat_row),
    .flags_o (lat_flags),
    .data_o  (lat_data)
  );

  nvm_array #(.ROW_W(ROW_W), .COL_W(COL_W), .INIT(ERASED)) u_array (
    .clk_i, .rst_ni,
    .we_i      (done),
    .wr_row_i  (lat_row),
    .mask_i    (lat_flags),
    .data_i    (lat_data),
    .rd_row_i  (addr_row),
    .rd_col_i  (addr_col),
    .rd_data_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rdata_o  <= '0;
      mem_rvalid_o <= 1'b0;
      mem_rd_err_o <= 1'b0;
    end else begin
      mem_rvalid_o <= mem_re_i && en_q;
      mem_rd_err_o <= mem_re_i && en_q && busy_o;
      if (mem_re_i && en_q) mem_rdata_o <= busy_o ? ERASED : arr_rdata;
    end
  end
endmodule

// File: rtl/nvm_writer_chk.sv
module nvm_writer_chk #(
  parameter int COLS        = 128,
  parameter int PROG_CYCLES = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ctl_we_i,
  input logic [7:0]      ctl_wdata_i,
  input logic            mem_re_i,
  input logic            en_q,
  input logic [COLS-1:0] lat_flags,
  input logic [7:0]      mem_rdata_o,
  input logic            mem_rvalid_o,
  input logic            mem_rd_err_o,
  input logic            busy_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  a_r7_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == PROG_CYCLES);

  a_r6_start_on_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ctl_we_i && ctl_wdata_i == 8'hA4));

  a_r9_start_needs_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(lat_flags != '0));

  a_r8_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> lat_flags == '0);

  a_r10_flags_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(lat_flags));

  a_r11_err_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_err_o |-> ($past(busy_o) && mem_rvalid_o && mem_rdata_o == 8'hFF));

  a_r12_rvalid_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_o |-> $past(mem_re_i && en_q));
endmodule

bind paged_nvm_writer nvm_writer_chk #(.COLS(COLS), .PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_we_i     (ctl_we_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .mem_re_i     (mem_re_i),
  .en_q         (en_q),
  .lat_flags    (lat_flags),
  .mem_rdata_o  (mem_rdata_o),
  .mem_rvalid_o (mem_rvalid_o),
  .mem_rd_err_o (mem_rd_err_o),
  .busy_o       (busy_o)
);

// File: tb/paged_nvm_writer_tb_top.sv
module paged_nvm_writer_tb_top;
  localparam int PROG = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        mem_we = 1'b0;
  logic        mem_re = 1'b0;
  logic [10:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, rd_err, busy;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  paged_nvm_writer #(.PROG_CYCLES(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .mem_we_i(mem_we), .mem_re_i(mem_re),
    .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .mem_rdata_o(rdata), .mem_rvalid_o(rvalid),
    .mem_rd_err_o(rd_err), .busy_o(busy)
  );

  // op: 0 latch write, 1 control write, 2 read and compare, 3 wait idle and compare length
  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 11'h000, 8'h01},  // enable
    {2'd0, 11'h105, 8'h11},  // row 2 col 5, locks row 2
    {2'd0, 11'h106, 8'h22},
    {2'd0, 11'h185, 8'h33},  // row 3: dropped (R5)
    {2'd0, 11'h105, 8'h44},  // overwrite (R5)
    {2'd1, 11'h000, 8'h54},
    {2'd1, 11'h000, 8'hA4},
    {2'd3, 11'h000, 8'd64},  // R7
    {2'd2, 11'h105, 8'h44},
    {2'd2, 11'h106, 8'h22},
    {2'd2, 11'h107, 8'hFF},  // unflagged (R4)
    {2'd2, 11'h185, 8'hFF},  // foreign row (R5)
    {2'd2, 11'h005, 8'hFF},  // row 0 same column (R3)
    {2'd0, 11'h187, 8'h55},  // new session locks row 3
    {2'd0, 11'h108, 8'h66},  // row 2 now dropped
    {2'd1, 11'h000, 8'h54},
    {2'd1, 11'h000, 8'hA4},
    {2'd3, 11'h000, 8'd64},
    {2'd2, 11'h187, 8'h55},
    {2'd2, 11'h108, 8'hFF},
    {2'd2, 11'h105, 8'h44}   // earlier pass kept
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic lat_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  // returns data and valid seen one cycle after the request edge
  task automatic rd(input logic [10:0] a, output logic [7:0] d, output logic v, output logic e);
    @(negedge clk); mem_re = 1'b1; mem_addr = a;
    @(negedge clk); d = rdata; v = rvalid; e = rd_err; mem_re = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL R7: watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v, e;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 rvalid after reset", rvalid, 0);
    chk("R1 rd_err after reset", rd_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // disabled port: reads and writes dropped (R2)
    rd(11'h000, d, v, e);
    chk("R2 read while disabled", v, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: lat_wr(VEC[i][18:8], VEC[i][7:0]);
        2'd1: ctl_wr(VEC[i][7:0]);
        2'd2: begin
          rd(VEC[i][18:8], d, v, e);
          chk("R4 table readback", d, VEC[i][7:0]);
        end
        default: begin
          chk("R7 busy raised", busy, 1);
          wait_idle(n);
          chk("R7 busy length", n, VEC[i][7:0]);
        end
      endcase
    end

    // R1 erased content and R12 latency
    rd(11'h3FF, d, v, e);
    chk("R1 erased byte", d, 8'hFF);
    chk("R12 rvalid one cycle after request", v, 1);
    @(negedge clk);
    chk("R12 rvalid is a pulse", rvalid, 0);

    // R2: disable, write dropped, unlock finds nothing (R9)
    ctl_wr(8'h00);
    lat_wr(11'h200, 8'h77);
    rd(11'h200, d, v, e);
    chk("R2 no rvalid while disabled", v, 0);
    ctl_wr(8'h01);
    ctl_wr(8'h54);
    ctl_wr(8'hA4);
    chk("R9 empty unlock leaves idle", busy, 0);
    rd(11'h200, d, v, e);
    chk("R2 dropped write not programmed", d, 8'hFF);

    // R6: broken sequence
    lat_wr(11'h201, 8'h66);
    ctl_wr(8'h54);
    ctl_wr(8'h55);
    ctl_wr(8'hA4);
    chk("R6 interrupted sequence no start", busy, 0);
    ctl_wr(8'h54);
    ctl_wr(8'hA4);
    chk("R6 proper sequence starts", busy, 1);

    // R11 read during pass, R10 traffic during pass
    rd(11'h201, d, v, e);
    chk("R11 busy read data", d, 8'hFF);
    chk("R11 busy read valid", v, 1);
    chk("R11 busy read error", e, 1);
    @(negedge clk);
    chk("R11 error is one cycle", rd_err, 0);
    lat_wr(11'h202, 8'h99);
    ctl_wr(8'h54);
    ctl_wr(8'hA4);
    wait_idle(n);
    chk("R10 unlock while busy does not extend", n < PROG, 1);
    rd(11'h201, d, v, e);
    chk("R6 committed byte", d, 8'h66);
    rd(11'h202, d, v, e);
    chk("R10 write while busy dropped", d, 8'hFF);
    ctl_wr(8'h54);
    ctl_wr(8'hA4);
    chk("R8 flags cleared, no restart", busy, 0);

    // R4 full page on row 15, R3 neighbour row intact
    for (int c = 0; c < 128; c++) lat_wr({4'hF, 7'(c)}, 8'(c) ^ 8'h5A);
    ctl_wr(8'h54);
    ctl_wr(8'hA4);
    wait_idle(n);
    chk("R7 full page busy length", n, PROG);
    rd(11'h780, d, v, e);
    chk("R4 full page first byte", d, 8'h5A);
    rd(11'h7FF, d, v, e);
    chk("R4 full page last byte", d, 8'h7F ^ 8'h5A);
    rd(11'h77F, d, v, e);
    chk("R3 row 14 untouched", d, 8'hFF);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule